// File: doc/BRIEF.md
# Banked Per-Task Return Address Stack

This block holds return addresses for a processor core that interleaves several hardware tasks on one pipeline. Each task owns a private last-in-first-out stack of program-counter values, selected by the task id that comes with every operation. A call pushes the return address onto the stack of the issuing task, and a return pops it. Because the stacks are separate, two tasks can run the same subroutine at the same time and neither overwrites the other's return address.

Explicit push, pop and a non-destructive peek act on the same stack. A global link mode, switched on and off by operation codes, sends the return address of a call to a register write port instead of the stack. The target register address equals the task number. All results appear on registered outputs one clock after the operation is presented. Overflow is recorded per task and stays set until reset. Reading an empty stack returns zero and is flagged.

Top module: `task_return_stack`

## Requirements
- R1: After a synchronous reset (rst high at a clock edge) all stacks are empty, link mode is off, and `rvalid_o`, `unf_o`, `lr_we_o` and every bit of `ovf_o` are 0.
- R2: Operation codes on `op_i` are 0 idle, 1 call, 2 return, 3 push, 4 pop, 5 peek, 6 link mode on, 7 link mode off. With link mode off, a call pushes `data_i` onto the stack of task `task_i`, and a return pops that stack.
- R3: Any operation that reads a stack (return with link mode off, pop, peek) raises `rvalid_o` in the cycle after the operation, with the value on `rdata_o`. `rvalid_o` is low in every other cycle.
- R4: Each stack is last-in-first-out and holds DEPTH entries (4 by default, 8 allowed). Values are the full 16-bit width with no bit lost.
- R5: A peek returns the most recently pushed value of the task and leaves the stack unchanged, so a following pop returns the same value.
- R6: The stacks are independent. An operation on one task never changes the contents of another task's stack, including when the task id changes every cycle.
- R7: A push to a full stack discards its oldest entry, stores the new value, and sets bit `task_i` of `ovf_o`. That bit stays set until reset.
- R8: A pop, peek or stack return on an empty stack gives `rdata_o` = 0 with `rvalid_o` and `unf_o` high for one cycle, and the stack stays empty.
- R9: With link mode on, a call leaves every stack unchanged. In the following cycle it raises `lr_we_o` for one cycle with `lr_addr_o` = the task id and `lr_data_o` = `data_i`.
- R10: With link mode on, a return leaves the stack alone and produces no `rvalid_o`. Push, pop and peek act on the stacks whatever the mode.
- R11: `lr_we_o` and `rvalid_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code |
| task_i | input | $clog2(TASKS) | Task issuing the operation |
| data_i | input | DW | Return address or value to push |
| rvalid_o | output | 1 | Read result valid |
| rdata_o | output | DW | Popped or peeked value |
| unf_o | output | 1 | Read found its stack empty |
| lr_we_o | output | 1 | Link register write strobe |
| lr_addr_o | output | $clog2(TASKS) | Link register address |
| lr_data_o | output | DW | Link register write data |
| ovf_o | output | TASKS | Sticky overflow flag per task |

## Verification
Two functions can coincide in one clock. A push that finds its stack full must drop the oldest entry and set the sticky overflow bit in the same edge. A switch of task id can also land on the cycle where another task's stack is being written or popped. Both are provoked on purpose: a fifth push runs into a four-deep stack, and back-to-back operations alternate the task id on every cycle. A reference model of four independent queues in the bench judges the result. It compares every read, the empty flag and the overflow vector after each operation, and the later pops show whether the neighbouring stacks kept their contents.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_CALL     = 3'd1,
    OP_RET      = 3'd2,
    OP_PUSH     = 3'd3,
    OP_POP      = 3'd4,
    OP_PEEK     = 3'd5,
    OP_LINK_ON  = 3'd6,
    OP_LINK_OFF = 3'd7
  } rs_op_e;
endpackage

// File: rtl/rs_task_ctrl.sv
// Pointer and occupancy tracking for one task's circular stack.
module rs_task_ctrl #(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  output logic [PW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [PW:0] count_q;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == (PW+1)'(DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      top_o   <= '1;
      count_q <= '0;
    end else if (push_i) begin
      top_o <= top_o + 1'b1;             // wraps, so a full push overwrites the oldest slot
      if (!full_o) count_q <= count_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      top_o   <= top_o - 1'b1;
      count_q <= count_q - 1'b1;
    end
  end
endmodule

// File: rtl/rs_store.sv
// Shared storage for all task stacks: one write port, one registered read port.
module rs_store #(
  parameter int TASKS = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int AW   = $clog2(TASKS * DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [TASKS*DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem[raddr_i];
  end
endmodule

// File: rtl/task_return_stack.sv
module task_return_stack #(
  parameter int TASKS = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 16,
  localparam int TW   = $clog2(TASKS),
  localparam int PW   = $clog2(DEPTH),
  localparam int AW   = TW + PW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       op_i,
  input  logic [TW-1:0]    task_i,
  input  logic [DW-1:0]    data_i,
  output logic             rvalid_o,
  output logic [DW-1:0]    rdata_o,
  output logic             unf_o,
  output logic             lr_we_o,
  output logic [TW-1:0]    lr_addr_o,
  output logic [DW-1:0]    lr_data_o,
  output logic [TASKS-1:0] ovf_o
);
  import rs_pkg::*;

  rs_op_e        op;
  logic          link_q;
  logic          stk_push, stk_read, stk_pop;
  logic [PW-1:0] tops   [TASKS];
  logic [TASKS-1:0] empties, fulls;
  logic [PW-1:0] sel_top;
  logic          sel_empty, sel_full;
  logic          zero_q;
  logic [DW-1:0] store_rd;

  assign op = rs_op_e'(op_i);

  always_comb begin
    stk_push = (op == OP_PUSH) || (op == OP_CALL && !link_q);
    stk_read = (op == OP_POP) || (op == OP_PEEK) || (op == OP_RET && !link_q);
    stk_pop  = stk_read && (op != OP_PEEK);
  end

  assign sel_top   = tops[task_i];
  assign sel_empty = empties[task_i];
  assign sel_full  = fulls[task_i];

  for (genvar t = 0; t < TASKS; t++) begin : g_task
    rs_task_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk     (clk),
      .rst     (rst),
      .push_i  (stk_push && task_i == TW'(t)),
      .pop_i   (stk_pop  && task_i == TW'(t)),
      .top_o   (tops[t]),
      .empty_o (empties[t]),
      .full_o  (fulls[t])
    );
  end

  rs_store #(.TASKS(TASKS), .DEPTH(DEPTH), .DW(DW)) u_store (
    .clk     (clk),
    .we_i    (stk_push),
    .waddr_i ({task_i, PW'(sel_top + 1'b1)}),
    .wdata_i (data_i),
    .re_i    (stk_read),
    .raddr_i ({task_i, sel_top}),
    .rdata_o (store_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      link_q    <= 1'b0;
      rvalid_o  <= 1'b0;
      zero_q    <= 1'b0;
      unf_o     <= 1'b0;
      lr_we_o   <= 1'b0;
      lr_addr_o <= '0;
      lr_data_o <= '0;
      ovf_o     <= '0;
    end else begin
      if (op == OP_LINK_ON)  link_q <= 1'b1;
      if (op == OP_LINK_OFF) link_q <= 1'b0;
      rvalid_o <= stk_read;
      zero_q   <= stk_read && sel_empty;
      unf_o    <= stk_read && sel_empty;
      lr_we_o  <= (op == OP_CALL) && link_q;
      if ((op == OP_CALL) && link_q) begin
        lr_addr_o <= task_i;
        lr_data_o <= data_i;
      end
      if (stk_push && sel_full) ovf_o[task_i] <= 1'b1;
    end
  end

  assign rdata_o = zero_q ? '0 : store_rd;
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
  parameter int TASKS = 4,
  parameter int DW    = 16,
  localparam int TW   = $clog2(TASKS)
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       op_i,
  input logic [TW-1:0]    task_i,
  input logic [DW-1:0]    data_i,
  input logic             rvalid_o,
  input logic [DW-1:0]    rdata_o,
  input logic             unf_o,
  input logic             lr_we_o,
  input logic [TW-1:0]    lr_addr_o,
  input logic [DW-1:0]    lr_data_o,
  input logic [TASKS-1:0] ovf_o,
  input logic             link_q
);
  a_r3_read_gives_valid: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd4 || op_i == 3'd5) |=> rvalid_o);

  a_r3_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    (op_i != 3'd2 && op_i != 3'd4 && op_i != 3'd5) |=> !rvalid_o);

  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o)));

  a_r8_underflow_reads_zero: assert property (@(posedge clk) disable iff (rst)
    unf_o |-> (rvalid_o && rdata_o == '0));

  a_r9_link_write: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd1 && link_q) |=>
      (lr_we_o && lr_addr_o == $past(task_i) && lr_data_o == $past(data_i)));

  a_r10_link_ret_silent: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd2 && link_q) |=> !rvalid_o);

  a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(lr_we_o && rvalid_o));
endmodule

bind task_return_stack rs_checker #(.TASKS(TASKS), .DW(DW)) u_chk (.*);

// File: tb/tb_task_return_stack.sv
module tb_task_return_stack;
  localparam int TASKS = 4;
  localparam int DEPTH = 4;
  localparam int DW    = 16;
  localparam int TW    = $clog2(TASKS);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       op_i = 3'd0;
  logic [TW-1:0]    task_i = '0;
  logic [DW-1:0]    data_i = '0;
  logic             rvalid_o, unf_o, lr_we_o;
  logic [DW-1:0]    rdata_o, lr_data_o;
  logic [TW-1:0]    lr_addr_o;
  logic [TASKS-1:0] ovf_o;

  always #4 clk = ~clk;  // 125 MHz

  task_return_stack #(.TASKS(TASKS), .DEPTH(DEPTH), .DW(DW)) dut (.*);

  typedef struct packed {
    logic             rv;
    logic [DW-1:0]    rd;
    logic             unf;
    logic             lwe;
    logic [TW-1:0]    laddr;
    logic [DW-1:0]    ldata;
    logic [TASKS-1:0] ovf;
  } exp_t;

  exp_t  exp_q [$];
  string tag_q [$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    finished = 0;

  // reference model
  int    mstk [TASKS][$];
  bit    mlink = 0;
  logic [TASKS-1:0] movf = '0;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t  e;
      string tg;
      e  = exp_q.pop_front();
      tg = tag_q.pop_front();
      n_vec++;
      if (rvalid_o !== e.rv || (e.rv && rdata_o !== e.rd) || unf_o !== e.unf ||
          lr_we_o !== e.lwe || (e.lwe && (lr_addr_o !== e.laddr || lr_data_o !== e.ldata)) ||
          ovf_o !== e.ovf) begin
        n_bad++;
        $display("FAIL %s: act rv=%0b rd=%h unf=%0b lwe=%0b la=%0d ld=%h ovf=%b exp rv=%0b rd=%h unf=%0b lwe=%0b la=%0d ld=%h ovf=%b",
                 tg, rvalid_o, rdata_o, unf_o, lr_we_o, lr_addr_o, lr_data_o, ovf_o,
                 e.rv, e.rd, e.unf, e.lwe, e.laddr, e.ldata, e.ovf);
      end
    end
  end

  task automatic do_op(input int o, input int t, input int d, input string tg);
    exp_t e;
    e = '0;
    @(negedge clk);
    op_i = 3'(o); task_i = TW'(t); data_i = DW'(d);
    case (o)
      1, 3: begin
        if (o == 1 && mlink) begin
          e.lwe = 1'b1; e.laddr = TW'(t); e.ldata = DW'(d);
        end else begin
          if (mstk[t].size() == DEPTH) begin
            void'(mstk[t].pop_front());
            movf[t] = 1'b1;
          end
          mstk[t].push_back(d & 16'hFFFF);
        end
      end
      2, 4, 5: begin
        if (!(o == 2 && mlink)) begin
          e.rv = 1'b1;
          if (mstk[t].size() == 0) begin
            e.unf = 1'b1; e.rd = '0;
          end else if (o == 5) e.rd = DW'(mstk[t][$]);
          else e.rd = DW'(mstk[t].pop_back());
        end
      end
      6: mlink = 1;
      7: mlink = 0;
      default: ;
    endcase
    e.ovf = movf;
    @(posedge clk);
    #1;
    exp_q.push_back(e);
    tag_q.push_back(tg);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: act running exp done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    n_vec++;
    if (rvalid_o !== 1'b0 || unf_o !== 1'b0 || lr_we_o !== 1'b0 || ovf_o !== '0) begin
      n_bad++;
      $display("FAIL R1: act rv=%0b unf=%0b lwe=%0b ovf=%b exp 0 0 0 0", rvalid_o, unf_o, lr_we_o, ovf_o);
    end
    // R1/R8: every stack empty after reset
    for (int t = 0; t < TASKS; t++) do_op(4, t, 0, "R1 R8 empty after reset");

    // R2 R3: call then return on task 0
    do_op(1, 0, 16'h1234, "R2 call");
    do_op(2, 0, 0, "R2 R3 return");
    // R4: LIFO order and 16-bit width
    do_op(1, 0, 16'hFFFF, "R4 push");
    do_op(3, 0, 16'h8001, "R4 push");
    do_op(3, 0, 16'h0000, "R4 push");
    do_op(4, 0, 0, "R4 lifo pop");
    do_op(4, 0, 0, "R4 lifo pop");
    do_op(2, 0, 0, "R4 lifo ret");
    // R5: peek is non-destructive
    do_op(3, 2, 16'hBEEF, "R5 push");
    do_op(5, 2, 0, "R5 peek");
    do_op(5, 2, 0, "R5 peek again");
    do_op(4, 2, 0, "R5 pop after peek");
    do_op(5, 2, 0, "R5 R8 peek empty");
    // R6: task id changes every cycle
    for (int i = 0; i < 3; i++)
      for (int t = 0; t < TASKS; t++) do_op(1, t, (t << 12) | (i << 4) | 5, "R6 interleaved call");
    for (int i = 0; i < 3; i++)
      for (int t = TASKS - 1; t >= 0; t--) do_op(2, t, 0, "R6 interleaved ret");
    // R7: overflow on task 1, others untouched
    do_op(3, 3, 16'h3333, "R6 neighbour push");
    for (int i = 0; i < DEPTH + 1; i++) do_op(3, 1, 16'hA000 + i, "R7 fill past depth");
    do_op(3, 1, 16'hA0FF, "R7 second overflow");
    for (int i = 0; i < DEPTH; i++) do_op(4, 1, 0, "R7 oldest dropped");
    do_op(4, 1, 0, "R7 R8 empty after drain");
    do_op(4, 3, 0, "R6 neighbour intact");
    // R9 R10: link mode
    do_op(3, 2, 16'h2222, "R10 push before link");
    do_op(6, 0, 0, "R9 link on");
    do_op(1, 2, 16'h4567, "R9 link call");
    do_op(1, 3, 16'hC0DE, "R9 link call task3");
    do_op(2, 2, 0, "R10 link return silent");
    do_op(3, 2, 16'h5555, "R10 push in link mode");
    do_op(5, 2, 0, "R10 peek in link mode");
    do_op(4, 2, 0, "R10 pop in link mode");
    do_op(4, 2, 0, "R10 stack untouched by link call");
    do_op(7, 0, 0, "R9 link off");
    do_op(1, 2, 16'h6789, "R2 call after link off");
    do_op(2, 2, 0, "R2 R11 return after link off");
    // random mix, all requirements
    for (int i = 0; i < 400; i++)
      do_op($urandom_range(0, 7), $urandom_range(0, TASKS - 1), $urandom_range(0, 16'hFFFF),
            "R11 R6 random mix");
    do_op(0, 0, 0, "R3 idle");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule